// File: doc/BRIEF.md
# Per-Core Supply Rail Selector

A cluster of processor cores shares two supply rails, a low one (0.81 V) and a high one (0.99 V), and runs at one common target frequency (830 MHz by default). Each core has a critical-path monitor. Its output arrives here as a digitised maximum-frequency code in MHz, one code for operation at the low rail and one for operation at the high rail. On every evaluate strobe the block decides, core by core, which rail that core should use. A core that cannot reach the target on the low rail is moved up. A core already on the high rail moves back down only when its low-rail code clears the target by a programmable hysteresis margin.

The block registers one rail-select bit per core and a flag that is set when every core reaches the target on the rail it now uses. Both change only at an evaluation. A done pulse follows one cycle after the rails update. The target and the hysteresis margin sit in two registers that can be written at any time. An evaluation always uses the values held before the edge on which it is sampled.

Top module: `rail_sel_ctrl`

## Requirements
- R1: After reset every rail-select bit is 0 (low rail), done_o is 0 and all_meet_o is 0; the target resets to 830 and the hysteresis margin to 16.
- R2: On an evaluation, a core on the low rail whose low-rail code is below the target gets rail bit 1 (high rail). A core whose code equals or exceeds the target keeps bit 0.
- R3: Rail bits and all_meet_o change only at the clock edge that samples eval_i high; code changes without a strobe have no effect on them.
- R4: On an evaluation, a core on the high rail returns to bit 0 only if its low-rail code is at least target plus hysteresis; at one below that sum it stays on bit 1.
- R5: A core that stays on the high rail is judged on its high-rail code; a high-rail code below the target keeps the core on bit 1 but clears all_meet_o.
- R6: all_meet_o, updated on the same edge as the rail bits, is 1 exactly when every core's code on its newly selected rail is at least the target.
- R7: done_o is high for one cycle, one cycle after the rail bits update (two edges after eval_i is sampled).
- R8: A target write and an evaluation in the same cycle: the evaluation uses the previous target, and the new target applies from the next evaluation.
- R9: A hysteresis write and an evaluation in the same cycle: the evaluation uses the previous margin, and the new margin applies from the next evaluation.
- R10: Target plus hysteresis is formed one bit wider than the code, so a target of 4095 with margin 255 never lets a high-rail core return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tgt_we_i | input | 1 | Write strobe for the target register |
| tgt_wdata_i | input | 12 | New target frequency code (MHz) |
| hyst_we_i | input | 1 | Write strobe for the hysteresis register |
| hyst_wdata_i | input | 8 | New hysteresis margin (MHz) |
| eval_i | input | 1 | Evaluate strobe |
| f_lo_i | input | 192 | Low-rail frequency codes, core n at bits [12n+11:12n] |
| f_hi_i | input | 192 | High-rail frequency codes, same packing |
| rail_hi_o | output | 16 | Per-core rail select, 1 = high rail |
| all_meet_o | output | 1 | Every core meets the target on its rail |
| done_o | output | 1 | One-cycle pulse after an evaluation |

## Verification
Two functions of the block can land on the same edge: an evaluation and a write of the target or margin register. The bench provokes this by raising eval_i in the same cycle as tgt_we_i or hyst_we_i. The codes are chosen so that the old and new register values lead to opposite rail decisions. It then checks that the first pass follows the old value and a second pass follows the new one.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
  typedef enum logic {
    RAIL_LO = 1'b0,
    RAIL_HI = 1'b1
  } rail_e;

  localparam int unsigned TGT_RST_MHZ  = 830;
  localparam int unsigned HYST_RST_MHZ = 16;
endpackage

// File: rtl/rsel_cfg_regs.sv
module rsel_cfg_regs #(
  parameter int unsigned FW       = 12,
  parameter int unsigned HW       = 8,
  parameter int unsigned TGT_RST  = 830,
  parameter int unsigned HYST_RST = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tgt_we_i,
  input  logic [FW-1:0] tgt_wdata_i,
  input  logic          hyst_we_i,
  input  logic [HW-1:0] hyst_wdata_i,
  output logic [FW-1:0] tgt_o,
  output logic [HW-1:0] hyst_o
);
  logic [FW-1:0] tgt_q, tgt_d;
  logic [HW-1:0] hyst_q, hyst_d;

  always_comb begin
    tgt_d  = tgt_we_i  ? tgt_wdata_i  : tgt_q;
    hyst_d = hyst_we_i ? hyst_wdata_i : hyst_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= FW'(TGT_RST);
      hyst_q <= HW'(HYST_RST);
    end else begin
      tgt_q  <= tgt_d;
      hyst_q <= hyst_d;
    end
  end

  assign tgt_o  = tgt_q;
  assign hyst_o = hyst_q;
endmodule

// File: rtl/rsel_core_slice.sv
module rsel_core_slice
  import rsel_pkg::*;
#(
  parameter int unsigned FW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eval_i,
  input  logic [FW-1:0] f_lo_i,
  input  logic [FW-1:0] f_hi_i,
  input  logic [FW-1:0] tgt_i,
  input  logic [FW:0]   ret_thr_i,
  output logic          rail_hi_o,
  output logic          meet_nxt_o
);
  rail_e rail_q, rail_d;

  // Decision for the next rail, evaluated every cycle, loaded on eval_i.
  always_comb begin
    rail_d = rail_q;
    if (rail_q == RAIL_LO) begin
      if (f_lo_i < tgt_i) rail_d = RAIL_HI;
    end else begin
      if ({1'b0, f_lo_i} >= ret_thr_i) rail_d = RAIL_LO;
    end
  end

  always_comb begin
    if (rail_d == RAIL_HI) meet_nxt_o = (f_hi_i >= tgt_i);
    else                   meet_nxt_o = (f_lo_i >= tgt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rail_q <= RAIL_LO;
    else if (eval_i) rail_q <= rail_d;
  end

  assign rail_hi_o = (rail_q == RAIL_HI);
endmodule

// File: rtl/rail_sel_ctrl.sv
module rail_sel_ctrl
  import rsel_pkg::*;
#(
  parameter int unsigned NCORE    = 16,
  parameter int unsigned FW       = 12,
  parameter int unsigned HW       = 8,
  parameter int unsigned TGT_RST  = TGT_RST_MHZ,
  parameter int unsigned HYST_RST = HYST_RST_MHZ
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tgt_we_i,
  input  logic [FW-1:0]       tgt_wdata_i,
  input  logic                hyst_we_i,
  input  logic [HW-1:0]       hyst_wdata_i,
  input  logic                eval_i,
  input  logic [NCORE*FW-1:0] f_lo_i,
  input  logic [NCORE*FW-1:0] f_hi_i,
  output logic [NCORE-1:0]    rail_hi_o,
  output logic                all_meet_o,
  output logic                done_o
);
  localparam int unsigned PADW = FW + 1 - HW;

  logic [FW-1:0]    tgt_q;
  logic [HW-1:0]    hyst_q;
  logic [FW:0]      ret_thr;
  logic [NCORE-1:0] meet_nxt;

  logic all_meet_q, all_meet_d;
  logic eval_q, eval_d;
  logic done_q, done_d;

  rsel_cfg_regs #(
    .FW(FW), .HW(HW), .TGT_RST(TGT_RST), .HYST_RST(HYST_RST)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tgt_we_i     (tgt_we_i),
    .tgt_wdata_i  (tgt_wdata_i),
    .hyst_we_i    (hyst_we_i),
    .hyst_wdata_i (hyst_wdata_i),
    .tgt_o        (tgt_q),
    .hyst_o       (hyst_q)
  );

  // Return threshold carries one extra bit so it cannot wrap.
  assign ret_thr = {1'b0, tgt_q} + {{PADW{1'b0}}, hyst_q};

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    rsel_core_slice #(.FW(FW)) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .eval_i     (eval_i),
      .f_lo_i     (f_lo_i[g*FW +: FW]),
      .f_hi_i     (f_hi_i[g*FW +: FW]),
      .tgt_i      (tgt_q),
      .ret_thr_i  (ret_thr),
      .rail_hi_o  (rail_hi_o[g]),
      .meet_nxt_o (meet_nxt[g])
    );
  end

  always_comb begin
    all_meet_d = eval_i ? (&meet_nxt) : all_meet_q;
    eval_d     = eval_i;
    done_d     = eval_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_meet_q <= 1'b0;
      eval_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      all_meet_q <= all_meet_d;
      eval_q     <= eval_d;
      done_q     <= done_d;
    end
  end

  assign all_meet_o = all_meet_q;
  assign done_o     = done_q;
endmodule

// File: rtl/rsel_chk.sv
module rsel_chk #(
  parameter int unsigned NCORE = 16,
  parameter int unsigned FW    = 12,
  parameter int unsigned HW    = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                eval_i,
  input logic [NCORE*FW-1:0] f_lo_i,
  input logic [FW-1:0]       tgt_q,
  input logic [HW-1:0]       hyst_q,
  input logic [NCORE-1:0]    rail_hi_o,
  input logic                all_meet_o,
  input logic                done_o
);
  logic [FW:0] thr_c;
  assign thr_c = FW'(tgt_q) + (FW+1)'(hyst_q);

  // R3: rails and flag hold without a strobe
  a_r3_rails_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(rail_hi_o));
  a_r3_meet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(all_meet_o));

  // R7: done two edges after eval, and only then
  a_r7_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> ##1 done_o);
  a_r7_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(eval_i, 2));

  for (genvar g = 0; g < NCORE; g++) begin : g_chk
    // R2: slow core on low rail moves up
    a_r2_move_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && !rail_hi_o[g] && (f_lo_i[g*FW +: FW] < tgt_q)) |=> rail_hi_o[g]);
    // R4: high core below return threshold stays high
    a_r4_stay_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && rail_hi_o[g] && ({1'b0, f_lo_i[g*FW +: FW]} < thr_c)) |=> rail_hi_o[g]);
  end
endmodule

bind rail_sel_ctrl rsel_chk #(.NCORE(NCORE), .FW(FW), .HW(HW)) u_rsel_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eval_i     (eval_i),
  .f_lo_i     (f_lo_i),
  .tgt_q      (tgt_q),
  .hyst_q     (hyst_q),
  .rail_hi_o  (rail_hi_o),
  .all_meet_o (all_meet_o),
  .done_o     (done_o)
);

// File: tb/test_rail_sel_ctrl.sv
`timescale 1ns/1ps
module test_rail_sel_ctrl;
  localparam int NC = 16;
  localparam int FW = 12;
  localparam int HW = 8;

  typedef struct packed {
    logic [FW-1:0] base;
    logic [NC-1:0] mask;
    logic [FW-1:0] slow;
    logic [FW-1:0] hi;
    logic [NC-1:0] erail;
    logic          emeet;
  } vec_t;

  // Walked in order; rail state carries from row to row (tgt 830, hyst 16).
  localparam vec_t TBL [8] = '{
    '{12'd862, 16'h0310, 12'd826,  12'd1370, 16'h0310, 1'b1}, // R2 slow cores up
    '{12'd862, 16'h0310, 12'd845,  12'd1370, 16'h0310, 1'b1}, // R4 845 < 846 stays
    '{12'd862, 16'h0310, 12'd846,  12'd1370, 16'h0000, 1'b1}, // R4 846 returns
    '{12'd830, 16'h0001, 12'd829,  12'd1370, 16'h0001, 1'b1}, // R2 830 equal stays low
    '{12'd862, 16'h0001, 12'd829,  12'd800,  16'h0001, 1'b0}, // R5 weak high rail
    '{12'd900, 16'h0000, 12'd900,  12'd1370, 16'h0000, 1'b1}, // R4 900 returns
    '{12'd862, 16'hFFFF, 12'd100,  12'd1400, 16'hFFFF, 1'b1}, // R2 all up
    '{12'd862, 16'hFFFF, 12'd845,  12'd1400, 16'hFFFF, 1'b1}  // R4 all stay
  };

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic               tgt_we_i, hyst_we_i, eval_i;
  logic [FW-1:0]      tgt_wdata_i;
  logic [HW-1:0]      hyst_wdata_i;
  logic [NC*FW-1:0]   f_lo_i, f_hi_i;
  logic [NC-1:0]      rail_hi_o;
  logic               all_meet_o, done_o;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk_i = ~clk_i;

  rail_sel_ctrl i_rail_sel_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tgt_we_i(tgt_we_i), .tgt_wdata_i(tgt_wdata_i),
    .hyst_we_i(hyst_we_i), .hyst_wdata_i(hyst_wdata_i),
    .eval_i(eval_i), .f_lo_i(f_lo_i), .f_hi_i(f_hi_i),
    .rail_hi_o(rail_hi_o), .all_meet_o(all_meet_o), .done_o(done_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 20000)", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_codes(input logic [FW-1:0] base, input logic [NC-1:0] mask,
                           input logic [FW-1:0] slow, input logic [FW-1:0] hi);
    for (int i = 0; i < NC; i++) begin
      f_lo_i[i*FW +: FW] = mask[i] ? slow : base;
      f_hi_i[i*FW +: FW] = hi;
    end
  endtask

  // Pulse eval at a negedge; check rails and flag after the next edge, then done.
  task automatic eval_pass(input string req, input logic [NC-1:0] erail, input logic emeet);
    eval_i = 1'b1;
    @(negedge clk_i);
    eval_i = 1'b0; tgt_we_i = 1'b0; hyst_we_i = 1'b0;
    chk(req, 32'(rail_hi_o), 32'(erail));
    chk(req, 32'(all_meet_o), 32'(emeet));
    chk("R7", 32'(done_o), 32'd0);
    @(negedge clk_i);
    chk("R7", 32'(done_o), 32'd1);
    @(negedge clk_i);
    chk("R7", 32'(done_o), 32'd0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    tgt_we_i = 0; hyst_we_i = 0; eval_i = 0;
    tgt_wdata_i = '0; hyst_wdata_i = '0;
    set_codes(12'd862, '0, 12'd862, 12'd1370);
    do_reset();

    // R1 reset state
    chk("R1", 32'(rail_hi_o), 32'd0);
    chk("R1", 32'(done_o), 32'd0);
    chk("R1", 32'(all_meet_o), 32'd0);

    for (int k = 0; k < 8; k++) begin
      set_codes(TBL[k].base, TBL[k].mask, TBL[k].slow, TBL[k].hi);
      eval_pass($sformatf("R6 row %0d", k), TBL[k].erail, TBL[k].emeet);
    end

    // R3: codes move without a strobe; rails and flag hold
    set_codes(12'd10, '0, 12'd10, 12'd10);
    repeat (4) @(negedge clk_i);
    chk("R3", 32'(rail_hi_o), 32'hFFFF);
    chk("R3", 32'(all_meet_o), 32'd1);

    // R1 reset values of target and margin seen through behaviour
    do_reset();
    set_codes(12'd830, '0, 12'd830, 12'd1370);
    eval_pass("R1 target 830", 16'h0000, 1'b1);

    // R8: target write together with eval uses old target 830
    set_codes(12'd850, '0, 12'd850, 12'd1370);
    tgt_we_i = 1'b1; tgt_wdata_i = 12'd900;
    eval_pass("R8 old target", 16'h0000, 1'b1);
    eval_pass("R8 new target", 16'hFFFF, 1'b1);

    // R9: margin write with eval uses old margin 16 (thr 916)
    set_codes(12'd1050, '0, 12'd1050, 12'd1370);
    hyst_we_i = 1'b1; hyst_wdata_i = 8'd200;
    eval_pass("R9 old margin", 16'h0000, 1'b1);
    set_codes(12'd850, '0, 12'd850, 12'd1370);
    eval_pass("R9 up again", 16'hFFFF, 1'b1);
    set_codes(12'd1050, '0, 12'd1050, 12'd1370);
    eval_pass("R9 new margin", 16'hFFFF, 1'b1);

    // R10: target 4095 + margin 255 does not wrap
    tgt_we_i = 1'b1; tgt_wdata_i = 12'd4095;
    hyst_we_i = 1'b1; hyst_wdata_i = 8'd255;
    @(negedge clk_i);
    tgt_we_i = 1'b0; hyst_we_i = 1'b0;
    set_codes(12'd4095, '0, 12'd4095, 12'd4095);
    eval_pass("R10 no wrap", 16'hFFFF, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule